// File: doc/BRIEF.md
# Half-Precision Sign-Injection and Register Move Unit

This combinational unit handles the half-precision operations of a 64-bit floating-point register file that need no arithmetic. It takes two floating-point register values, one integer register value and a 3-bit operation code. It produces a 64-bit floating-point result and a 64-bit integer result in the same cycle. Before use, each floating-point operand is checked for a correct box, meaning all 48 upper bits are ones. An operand that fails this check is replaced by the canonical half-precision NaN, 0x7E00.

Three operations copy the magnitude of the first operand and choose a new sign bit: the second operand's sign, its inverse, or the XOR of both signs. Two more operations copy raw bits between the register files. A move to the integer side sign-extends bit 15. A move to the floating-point side boxes the low 16 bits. The unit raises no exception flags and does no rounding.

Top module: `hsm_unit`

## Requirements
- R1: A floating-point operand whose bits 63..16 are not all ones is used by the sign-injection operations as the half-precision value 0x7E00. A correctly boxed operand is used as its bits 15..0.
- R2: For op codes 0, 1, 2 and 4, `fres_o[63:16]` is all ones and the half-precision result is in `fres_o[15:0]`.
- R3: Op code 0 (copy sign) gives `fres_o[14:0]` equal to the first operand's bits 14..0 and `fres_o[15]` equal to the second operand's bit 15, both operands taken after the R1 check.
- R4: Op code 1 (inverted sign) works as R3, except that `fres_o[15]` is the inverse of the second operand's bit 15.
- R5: Op code 2 (XOR sign) works as R3, except that `fres_o[15]` is the XOR of bit 15 of both operands.
- R6: Op code 3 (floating to integer move) gives `xres_o[15:0]` equal to `fs1_i[15:0]` and every bit of `xres_o[63:16]` equal to `fs1_i[15]`. The box check of R1 is not applied, and `fres_o` is zero.
- R7: Op code 4 (integer to floating move) gives `fres_o[15:0]` equal to `xs1_i[15:0]`. Bits 63..16 of `xs1_i` have no effect on the result.
- R8: For op codes 0, 1, 2 and 4, `xres_o` is zero. For op codes 5, 6 and 7, both outputs are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| fs1_i | input | 64 | First floating-point register value |
| fs2_i | input | 64 | Second floating-point register value |
| xs1_i | input | 64 | Integer register value |
| op_i | input | 3 | Operation code (0 copy sign, 1 inverted sign, 2 XOR sign, 3 float to integer, 4 integer to float) |
| fres_o | output | 64 | Boxed floating-point result |
| xres_o | output | 64 | Integer result |

## Verification
The hardest case to reach is an operand that is almost boxed: exactly one of the 48 upper bits is zero. A unit that tests only a few of the upper bits would pass every ordinary case and still be wrong. The stimulus walks a single zero across each upper bit position, first of the first operand and then of the second. It then checks that the canonical NaN appears in the result with the injected sign. The same raw values are also sent through the floating-to-integer move, where they must pass through unchanged.

// File: rtl/hsm_pkg.sv
// Shared definitions for the half-precision sign-injection and move unit.
// Assumes a 3-bit operation code; codes 5..7 are unused.
package hsm_pkg;
    typedef enum logic [2:0] {
        OP_SGN_COPY = 3'd0,
        OP_SGN_INV  = 3'd1,
        OP_SGN_XOR  = 3'd2,
        OP_MV_F2X   = 3'd3,
        OP_MV_X2F   = 3'd4
    } hsm_op_e;

    typedef enum logic [1:0] {
        SGN_COPY = 2'd0,
        SGN_INV  = 2'd1,
        SGN_XOR  = 2'd2
    } hsm_sgn_e;

    localparam logic [15:0] HALF_CANON_NAN = 16'h7E00;
endpackage

// File: rtl/hsm_unbox.sv
// Unbox check: takes the narrow value out of a wide register value.
// Assumes a value is validly boxed only when every bit above HW is one;
// any other value yields NAN_VAL.
module hsm_unbox #(
    parameter int FLEN = 64,
    parameter int HW = 16,
    parameter logic [HW-1:0] NAN_VAL = 16'h7E00
) (
    input  logic [FLEN-1:0] reg_i,
    output logic [HW-1:0]   half_o,
    output logic            boxed_o
);
    localparam int UPW = FLEN - HW;

    // Box test on the upper bits, then select the operand or the NaN.
    always_comb begin
        boxed_o = &reg_i[FLEN-1:HW];
        half_o  = boxed_o ? reg_i[HW-1:0] : NAN_VAL;
    end

    // R1: an operand that is not boxed must come out as the canonical NaN.
    always_comb begin
        if (reg_i[FLEN-1:HW] != {UPW{1'b1}})
            a_r1_unboxed_nan: assert (half_o == NAN_VAL);
    end
endmodule

// File: rtl/hsm_sgninj.sv
// Sign injection: keeps the magnitude of a_i and sets the sign from b_i.
// Assumes the sign is the top bit of the HW-bit value.
module hsm_sgninj #(
    parameter int HW = 16
) (
    input  logic [HW-1:0] a_i,
    input  logic [HW-1:0] b_i,
    input  hsm_pkg::hsm_sgn_e mode_i,
    output logic [HW-1:0] res_o
);
    import hsm_pkg::*;

    logic new_sign;

    // Choose the new sign bit for the selected mode.
    always_comb begin
        unique case (mode_i)
            SGN_COPY: new_sign = b_i[HW-1];
            SGN_INV:  new_sign = ~b_i[HW-1];
            SGN_XOR:  new_sign = a_i[HW-1] ^ b_i[HW-1];
            default:  new_sign = a_i[HW-1];
        endcase
    end

    // Put the chosen sign onto the unchanged magnitude.
    always_comb res_o = {new_sign, a_i[HW-2:0]};

    // R3: the magnitude bits are never altered.
    always_comb begin
        a_r3_magnitude_kept: assert (res_o[HW-2:0] == a_i[HW-2:0]);
    end
endmodule

// File: rtl/hsm_box.sv
// Boxes a narrow value into a wide register value by filling the upper bits with ones.
// Assumes FLEN > HW.
module hsm_box #(
    parameter int FLEN = 64,
    parameter int HW = 16
) (
    input  logic [HW-1:0]   half_i,
    output logic [FLEN-1:0] reg_o
);
    localparam int UPW = FLEN - HW;

    // Put the ones pattern above the value.
    always_comb reg_o = {{UPW{1'b1}}, half_i};
endmodule

// File: rtl/hsm_unit.sv
// Top level: combinational sign injection and register moves on half-precision values.
// Assumes a purely combinational context; results follow the inputs in the same cycle.
// Raises no exception flags.
module hsm_unit #(
    parameter int FLEN = 64,
    parameter int XLEN = 64,
    parameter int HW = 16
) (
    input  logic [FLEN-1:0] fs1_i,
    input  logic [FLEN-1:0] fs2_i,
    input  logic [XLEN-1:0] xs1_i,
    input  logic [2:0]      op_i,
    output logic [FLEN-1:0] fres_o,
    output logic [XLEN-1:0] xres_o
);
    import hsm_pkg::*;

    localparam int NSRC = 2;
    localparam int FUPW = FLEN - HW;
    localparam int XUPW = XLEN - HW;

    logic [FLEN-1:0] src_reg [NSRC];
    logic [HW-1:0]   src_half [NSRC];
    logic            src_boxed [NSRC];
    logic [HW-1:0]   inj_half;
    logic [HW-1:0]   box_in;
    logic [FLEN-1:0] boxed_val;
    hsm_sgn_e        sgn_mode;
    hsm_op_e         op;

    // Collect the floating-point sources for the unbox stage.
    always_comb begin
        src_reg[0] = fs1_i;
        src_reg[1] = fs2_i;
    end

    // One unbox check per floating-point source.
    for (genvar g = 0; g < NSRC; g++) begin : g_unbox
        hsm_unbox #(
            .FLEN(FLEN), .HW(HW), .NAN_VAL(HALF_CANON_NAN)
        ) u_unbox (
            .reg_i(src_reg[g]),
            .half_o(src_half[g]),
            .boxed_o(src_boxed[g])
        );
    end

    // Map the op code onto a sign-injection mode.
    always_comb begin
        op = hsm_op_e'(op_i);
        case (op)
            OP_SGN_INV: sgn_mode = SGN_INV;
            OP_SGN_XOR: sgn_mode = SGN_XOR;
            default:    sgn_mode = SGN_COPY;
        endcase
    end

    hsm_sgninj #(.HW(HW)) u_sgninj (
        .a_i(src_half[0]),
        .b_i(src_half[1]),
        .mode_i(sgn_mode),
        .res_o(inj_half)
    );

    // Choose which half value goes into the box stage.
    always_comb box_in = (op == OP_MV_X2F) ? xs1_i[HW-1:0] : inj_half;

    hsm_box #(.FLEN(FLEN), .HW(HW)) u_box (
        .half_i(box_in),
        .reg_o(boxed_val)
    );

    // Drive the outputs for each op code; unused outputs are zero.
    always_comb begin
        fres_o = '0;
        xres_o = '0;
        case (op)
            OP_SGN_COPY, OP_SGN_INV, OP_SGN_XOR, OP_MV_X2F:
                fres_o = boxed_val;
            OP_MV_F2X:
                xres_o = {{XUPW{fs1_i[HW-1]}}, fs1_i[HW-1:0]};
            default: ;
        endcase
    end

    // R2: every floating-point result is boxed.
    always_comb begin
        if (op_i <= 3'd2 || op_i == 3'd4)
            a_r2_result_boxed: assert (fres_o[FLEN-1:HW] == {FUPW{1'b1}});
    end

    // R5: the XOR sign comes from the two unboxed operand signs.
    always_comb begin
        if (op_i == 3'd2)
            a_r5_xor_sign: assert (fres_o[HW-1] == (src_half[0][HW-1] ^ src_half[1][HW-1]));
    end

    // R6: the move to the integer side bypasses the unbox check.
    always_comb begin
        if (op_i == 3'd3)
            a_r6_raw_move: assert (xres_o[HW-1:0] == fs1_i[HW-1:0] && fres_o == '0);
    end

    // R8: at most one output is non-zero.
    always_comb begin
        a_r8_one_output: assert (fres_o == '0 || xres_o == '0);
    end

    // R1: a boxed first operand keeps its magnitude in sign-injection results.
    always_comb begin
        if (op_i <= 3'd2 && src_boxed[0])
            a_r1_boxed_passes: assert (fres_o[HW-2:0] == fs1_i[HW-2:0]);
    end
endmodule

// File: tb/tb_hsm_unit.sv
module tb_hsm_unit;
    localparam time CLK_PERIOD = 10ns;
    localparam int WATCHDOG = 20000;

    logic clk = 1'b0;
    logic [63:0] fs1, fs2, xs1;
    logic [2:0]  op;
    logic [63:0] fres, xres;

    typedef struct {
        logic [63:0] f_exp;
        logic [63:0] x_exp;
        string tag;
    } item_t;

    item_t sb[$];
    int total = 0;
    int bad = 0;
    bit drv_done = 0;
    int cyc = 0;

    hsm_unit dut (
        .fs1_i(fs1), .fs2_i(fs2), .xs1_i(xs1), .op_i(op),
        .fres_o(fres), .xres_o(xres)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [15:0] ub(input logic [63:0] v);
        return (v[63:16] == 48'hFFFF_FFFF_FFFF) ? v[15:0] : 16'h7E00;
    endfunction

    // Reference model written from the requirements.
    function automatic void model(input logic [63:0] a, b, x, input logic [2:0] o,
                                  output logic [63:0] fe, xe);
        logic [15:0] ha, hb;
        ha = ub(a);
        hb = ub(b);
        fe = '0;
        xe = '0;
        case (o)
            3'd0: fe = {48'hFFFF_FFFF_FFFF, hb[15], ha[14:0]};
            3'd1: fe = {48'hFFFF_FFFF_FFFF, ~hb[15], ha[14:0]};
            3'd2: fe = {48'hFFFF_FFFF_FFFF, ha[15] ^ hb[15], ha[14:0]};
            3'd3: xe = {{48{a[15]}}, a[15:0]};
            3'd4: fe = {48'hFFFF_FFFF_FFFF, x[15:0]};
            default: ;
        endcase
    endfunction

    // Driver: applies a stimulus on the falling edge and queues its expectation.
    task automatic drive(input logic [63:0] a, b, x, input logic [2:0] o, input string tag);
        item_t it;
        @(negedge clk);
        fs1 = a; fs2 = b; xs1 = x; op = o;
        model(a, b, x, o, it.f_exp, it.x_exp);
        it.tag = tag;
        sb.push_back(it);
    endtask

    // Driver with a hand-computed expectation.
    task automatic drive_exp(input logic [63:0] a, b, x, input logic [2:0] o,
                             input logic [63:0] fe, xe, input string tag);
        item_t it;
        @(negedge clk);
        fs1 = a; fs2 = b; xs1 = x; op = o;
        it.f_exp = fe; it.x_exp = xe; it.tag = tag;
        sb.push_back(it);
    endtask

    // Monitor: pops one expectation per rising edge and compares it.
    always @(posedge clk) begin
        if (sb.size() > 0) begin
            item_t it;
            it = sb.pop_front();
            total++;
            if (fres !== it.f_exp || xres !== it.x_exp) begin
                bad++;
                $display("FAIL %s: fres=%h xres=%h expected fres=%h xres=%h",
                         it.tag, fres, xres, it.f_exp, it.x_exp);
            end
        end
    end

    // Watchdog: a hung run counts as a failed check.
    always @(posedge clk) begin
        cyc++;
        if (cyc > WATCHDOG) begin
            bad++;
            total++;
            $display("FAIL watchdog: cycles=%0d expected below %0d", cyc, WATCHDOG);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    localparam logic [63:0] BX = 64'hFFFF_FFFF_FFFF_0000;

    initial begin
        fs1 = '0; fs2 = '0; xs1 = '0; op = 3'd7;
        // R8: idle code gives zero outputs
        drive_exp('0, '0, '0, 3'd7, '0, '0, "R8 initial code 7");
        // R3 copy sign, hand-checked
        drive_exp(BX | 64'h3C00, BX | 64'h8000, '0, 3'd0, BX | 64'hBC00, '0, "R3 copy sign");
        // R4 inverted sign
        drive_exp(BX | 64'hBC00, BX | 64'hC000, '0, 3'd1, BX | 64'h3C00, '0, "R4 inverted sign");
        // R5 XOR sign
        drive_exp(BX | 64'hBC00, BX | 64'h8001, '0, 3'd2, BX | 64'h3C00, '0, "R5 xor sign");
        drive_exp(BX | 64'h3C00, BX | 64'h8001, '0, 3'd2, BX | 64'hBC00, '0, "R5 xor sign mixed");
        // R1 unboxed first operand becomes NaN, sign from second
        drive_exp(64'h0000_0000_0000_3C00, BX | 64'h8000, '0, 3'd0, BX | 64'hFE00, '0, "R1 unboxed fs1");
        // R1 unboxed second operand: its sign bit is 0 after substitution
        drive_exp(BX | 64'hBC00, 64'h1234_5678_0000_8000, '0, 3'd0, BX | 64'h3C00, '0, "R1 unboxed fs2");
        // R6 move to integer with sign extension, no unbox check
        drive_exp(64'h0000_0000_0000_8001, '0, '0, 3'd3, '0, 64'hFFFF_FFFF_FFFF_8001, "R6 negative move");
        drive_exp(BX | 64'h7FFF, '0, '0, 3'd3, '0, 64'h0000_0000_0000_7FFF, "R6 positive move");
        // R7 move to float ignores upper integer bits
        drive_exp('0, '0, 64'hDEAD_BEEF_CAFE_1234, 3'd4, BX | 64'h1234, '0, "R7 upper ignored");
        drive_exp('0, '0, 64'h0000_0000_0000_1234, 3'd4, BX | 64'h1234, '0, "R7 clean upper");
        // R8 unused codes
        drive_exp(BX | 64'h1111, BX | 64'h2222, 64'h3333, 3'd5, '0, '0, "R8 code 5");
        drive_exp(BX | 64'h1111, BX | 64'h2222, 64'h3333, 3'd6, '0, '0, "R8 code 6");
        // R1: single zero walked through each upper bit of each operand
        for (int k = 16; k < 64; k++) begin
            logic [63:0] nb;
            nb = BX | 64'h3C00;
            nb[k] = 1'b0;
            drive(nb, BX | 64'h8000, '0, 3'd0, "R1 near-boxed fs1");
            drive(BX | 64'h3C00, nb, '0, 3'd1, "R1 near-boxed fs2");
            drive(nb, '0, '0, 3'd3, "R6 near-boxed raw move");
        end
        // R2 mixed patterns over all codes
        for (int i = 0; i < 400; i++) begin
            logic [63:0] a, b, x;
            a = {$urandom, $urandom};
            b = {$urandom, $urandom};
            x = {$urandom, $urandom};
            if (i % 2 == 0) a[63:16] = '1;
            if (i % 3 == 0) b[63:16] = '1;
            drive(a, b, x, 3'(i % 8), "R2 mixed pattern");
        end
        drv_done = 1;
        @(negedge clk);
        @(negedge clk);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule